// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the sequence of element addresses for a single DMA channel. A start pulse captures a configuration: a start address, an inner (row) element count and signed step, an outer (column) count and signed step, and an element size. From then on, each accepted advance handshake consumes the current address and moves the generator to the next element. Inside a row the address moves by the inner step. At the end of a row it moves by the outer step instead, and the inner count reloads. Because the two steps are independent and signed, an outer step smaller than the inner step walks interleaved streams apart on the fly.

Two modes are supported. In stop mode the generator halts after the last element of the buffer and shows a done flag. In circular mode it reloads its start values and repeats without end. An interrupt pulse marks the end of each buffer and, when enabled, the end of every row. A one-dimensional transfer is the same engine with the outer count forced to one. The data bus, arbitration and descriptor fetch belong to the surrounding channel.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, busy_o, done_o and irq_o are 0 and addr_o is 0.
- R2: One cycle after a start pulse, busy_o is 1, done_o is 0 and addr_o equals cfg_base_i as it was at the start pulse.
- R3: An element is consumed when advance_i is 1 while busy_o is 1. If that element is not the last of its row, addr_o then moves by the inner step times the element size. Element-size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.
- R4: After the last element of a row that is not the last row, addr_o moves by the outer step times the element size, and the next row again has the full inner count of elements.
- R5: In stop mode (cfg_circular_i = 0), consuming the final element clears busy_o and sets done_o. addr_o keeps the final element's address. done_o stays 1, and advance_i has no effect, until the next start pulse.
- R6: In circular mode (cfg_circular_i = 1), after the final element addr_o returns to the start address, busy_o stays 1, and the whole pattern repeats.
- R7: irq_o is a one-cycle pulse in the cycle after the final element of a buffer is consumed. When cfg_row_irq_i is 1 it also pulses after the last element of every row. An element that ends both a row and the buffer gives a single pulse.
- R8: An inner or outer count of 0 means 65536 elements.
- R9: With cfg_two_d_i = 0 the outer count and outer step are ignored, and the buffer is one row of inner-count elements.
- R10: Both steps are 16-bit two's-complement values, and address arithmetic wraps modulo 2^32.
- R11: A start pulse while busy restarts the generator with the new configuration. It takes priority over an advance in the same cycle, and that advance consumes no element.
- R12: While busy_o is 1 and advance_i is 0, addr_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures the configuration |
| cfg_base_i | input | 32 | Start address |
| cfg_inner_cnt_i | input | 16 | Elements per row (0 = 65536) |
| cfg_inner_step_i | input | 16 | Signed step between elements of a row, in elements |
| cfg_outer_cnt_i | input | 16 | Number of rows (0 = 65536) |
| cfg_outer_step_i | input | 16 | Signed step applied after a row's last element, in elements |
| cfg_esize_i | input | 2 | Element size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| cfg_two_d_i | input | 1 | 1 = two-dimensional, 0 = one row only |
| cfg_circular_i | input | 1 | 1 = circular autobuffer, 0 = stop on completion |
| cfg_row_irq_i | input | 1 | 1 = also interrupt at each row end |
| advance_i | input | 1 | Consume the current element |
| addr_o | output | 32 | Address of the current element |
| busy_o | output | 1 | Generator active |
| done_o | output | 1 | Stop-mode buffer finished |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Two of this block's functions can fall on the same element: the end of a row and the end of the buffer. In circular mode with row interrupts enabled, that same element also triggers the reload to the start address. The bench provokes this by running several passes of a small circular buffer with row interrupts on, using an advance pattern that has gaps in it. The scoreboard expects exactly one interrupt pulse for that element and expects the next address to be the start address rather than the outer-step target. A second collision, a start pulse in the same cycle as an advance, is judged by checking that the new start address appears and that no element of the old stream is counted.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    // Element size codes; the two top codes both select 32-bit elements
    typedef enum logic [1:0] {
        ESZ_B8   = 2'd0,
        ESZ_B16  = 2'd1,
        ESZ_B32  = 2'd2,
        ESZ_B32X = 2'd3
    } esize_e;

    // Left shift that turns an element step into a byte offset
    function automatic logic [1:0] esize_shift(input logic [1:0] code);
        case (esize_e'(code))
            ESZ_B8:  return 2'd0;
            ESZ_B16: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/dma2d_step_scale.sv
module dma2d_step_scale
    import dma2d_pkg::*;
#(
    parameter int STEP_W = 16,
    parameter int ADDR_W = 32
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [1:0]        esize_i,
    output logic [ADDR_W-1:0] off_o
);
    localparam int EXT_W = ADDR_W - STEP_W;

    logic [ADDR_W-1:0] ext;

    always_comb begin
        ext   = {{EXT_W{step_i[STEP_W-1]}}, step_i};
        off_o = ext << esize_shift(esize_i);
    end
endmodule

// File: rtl/dma2d_dim_counter.sv
module dma2d_dim_counter #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] rem_q_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] rem_d_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Counts remaining elements down to one; zero stands for 2^CNT_W
    always_comb begin
        last_o  = (rem_q_i == ONE);
        rem_d_o = rem_q_i;
        if (tick_i) begin
            rem_d_o = last_o ? reload_i : (rem_q_i - ONE);
        end
    end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] cfg_base_i,
    input  logic [CNT_W-1:0]  cfg_inner_cnt_i,
    input  logic [STEP_W-1:0] cfg_inner_step_i,
    input  logic [CNT_W-1:0]  cfg_outer_cnt_i,
    input  logic [STEP_W-1:0] cfg_outer_step_i,
    input  logic [1:0]        cfg_esize_i,
    input  logic              cfg_two_d_i,
    input  logic              cfg_circular_i,
    input  logic              cfg_row_irq_i,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              irq_o
);
    localparam int NDIM = 2;
    localparam int DIM_IN  = 0;
    localparam int DIM_OUT = 1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] in_off;
        logic [ADDR_W-1:0] out_off;
        logic [CNT_W-1:0]  in_rem;
        logic [CNT_W-1:0]  out_rem;
        logic [CNT_W-1:0]  in_cnt;
        logic [CNT_W-1:0]  out_cnt;
        logic              circ;
        logic              row_irq;
        logic              busy;
        logic              done;
        logic              irq;
    } gen_state_t;

    gen_state_t st_q, st_d;

    // Byte offsets of the configured steps, captured at start
    logic [STEP_W-1:0] cfg_step_a [NDIM];
    logic [ADDR_W-1:0] cfg_off_a  [NDIM];

    // Per-dimension remaining-count logic
    logic [CNT_W-1:0] rem_q_a  [NDIM];
    logic [CNT_W-1:0] reload_a [NDIM];
    logic [CNT_W-1:0] rem_d_a  [NDIM];
    logic             tick_a   [NDIM];
    logic             last_a   [NDIM];

    logic adv;

    assign adv = st_q.busy && advance_i && !start_i;

    assign cfg_step_a[DIM_IN]  = cfg_inner_step_i;
    assign cfg_step_a[DIM_OUT] = cfg_outer_step_i;

    assign rem_q_a[DIM_IN]   = st_q.in_rem;
    assign rem_q_a[DIM_OUT]  = st_q.out_rem;
    assign reload_a[DIM_IN]  = st_q.in_cnt;
    assign reload_a[DIM_OUT] = st_q.out_cnt;
    assign tick_a[DIM_IN]    = adv;
    assign tick_a[DIM_OUT]   = adv && last_a[DIM_IN];

    for (genvar g = 0; g < NDIM; g++) begin : g_dim
        dma2d_step_scale #(
            .STEP_W (STEP_W),
            .ADDR_W (ADDR_W)
        ) u_scale (
            .step_i  (cfg_step_a[g]),
            .esize_i (cfg_esize_i),
            .off_o   (cfg_off_a[g])
        );

        dma2d_dim_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .rem_q_i  (rem_q_a[g]),
            .reload_i (reload_a[g]),
            .tick_i   (tick_a[g]),
            .rem_d_o  (rem_d_a[g]),
            .last_o   (last_a[g])
        );
    end

    // Next-state computation
    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (start_i) begin
            st_d.base    = cfg_base_i;
            st_d.addr    = cfg_base_i;
            st_d.in_off  = cfg_off_a[DIM_IN];
            st_d.out_off = cfg_off_a[DIM_OUT];
            st_d.in_cnt  = cfg_inner_cnt_i;
            st_d.in_rem  = cfg_inner_cnt_i;
            st_d.out_cnt = cfg_two_d_i ? cfg_outer_cnt_i : CNT_ONE;
            st_d.out_rem = cfg_two_d_i ? cfg_outer_cnt_i : CNT_ONE;
            st_d.circ    = cfg_circular_i;
            st_d.row_irq = cfg_row_irq_i;
            st_d.busy    = 1'b1;
            st_d.done    = 1'b0;
        end else if (adv) begin
            st_d.in_rem  = rem_d_a[DIM_IN];
            st_d.out_rem = rem_d_a[DIM_OUT];
            if (!last_a[DIM_IN]) begin
                st_d.addr = st_q.addr + st_q.in_off;
            end else if (!last_a[DIM_OUT]) begin
                st_d.addr = st_q.addr + st_q.out_off;
                st_d.irq  = st_q.row_irq;
            end else begin
                st_d.irq = 1'b1;
                if (st_q.circ) begin
                    st_d.addr = st_q.base;
                end else begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign irq_o  = st_q.irq;

    // R2: start loads the base address and activates
    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.busy && !st_q.done && st_q.addr == $past(cfg_base_i)));

    // R5: done and busy never together
    a_r5_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy);

    // R5: an idle generator keeps its address and done flag
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start_i) |=> ($stable(st_q.addr) && $stable(st_q.done)));

    // R6: circular mode never leaves busy without a new start
    a_r6_circ_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.circ && !start_i) |=> st_q.busy);

    // R7: an interrupt pulse always follows a consumed element
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(st_q.busy && advance_i && !start_i));

    // R12: no advance, no address movement
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !advance_i && !start_i) |=> $stable(st_q.addr));

endmodule

// File: tb/sim_dma2d_addr_gen.sv
module sim_dma2d_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        logic [31:0] a;
        bit          irq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] cfg_base_i = '0;
    logic [15:0] cfg_inner_cnt_i = '0;
    logic [15:0] cfg_inner_step_i = '0;
    logic [15:0] cfg_outer_cnt_i = '0;
    logic [15:0] cfg_outer_step_i = '0;
    logic [1:0]  cfg_esize_i = '0;
    logic        cfg_two_d_i = 1'b0;
    logic        cfg_circular_i = 1'b0;
    logic        cfg_row_irq_i = 1'b0;
    logic        advance_i = 1'b0;
    logic [31:0] addr_o;
    logic        busy_o, done_o, irq_o;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t q[$];
    bit   pend_irq = 1'b0;
    logic [31:0] last_addr = '0;
    bit   mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma2d_addr_gen u0 (
        .clk, .rst_n, .start_i, .cfg_base_i, .cfg_inner_cnt_i, .cfg_inner_step_i,
        .cfg_outer_cnt_i, .cfg_outer_step_i, .cfg_esize_i, .cfg_two_d_i,
        .cfg_circular_i, .cfg_row_irq_i, .advance_i, .addr_o, .busy_o, .done_o, .irq_o
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: scoreboard compare of consumed addresses and interrupt pulses
    always @(negedge clk) begin
        if (mon_on) begin
            if (irq_o !== pend_irq || pend_irq) begin
                chk(irq_o === pend_irq, "R7", "irq pulse", {31'd0, irq_o}, {31'd0, pend_irq});
            end
            pend_irq = 1'b0;
            if (busy_o && advance_i && !start_i) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R3 R4", "unexpected element", addr_o, 32'h0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(addr_o === e.a, "R3 R4", "element address", addr_o, e.a);
                    pend_irq  = e.irq;
                    last_addr = addr_o;
                end
            end
        end
    end

    // Driver side
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic cfg_start(input logic [31:0] base, input logic [15:0] ic, input logic [15:0] is,
                             input logic [15:0] oc, input logic [15:0] os, input logic [1:0] es,
                             input bit two_d, input bit circ, input bit rowirq, input bit with_adv);
        cfg_base_i = base; cfg_inner_cnt_i = ic; cfg_inner_step_i = is;
        cfg_outer_cnt_i = oc; cfg_outer_step_i = os; cfg_esize_i = es;
        cfg_two_d_i = two_d; cfg_circular_i = circ; cfg_row_irq_i = rowirq;
        start_i = 1'b1;
        advance_i = with_adv;
        cyc();
        start_i = 1'b0;
        advance_i = 1'b0;
    endtask

    // Expected stream computed from the captured configuration
    task automatic push_expected(input int passes);
        int n_in, n_out, scale, si, so;
        logic [31:0] a;
        n_in  = (cfg_inner_cnt_i == 0) ? 65536 : int'(cfg_inner_cnt_i);
        n_out = !cfg_two_d_i ? 1 : ((cfg_outer_cnt_i == 0) ? 65536 : int'(cfg_outer_cnt_i));
        scale = (cfg_esize_i == 2'd0) ? 1 : ((cfg_esize_i == 2'd1) ? 2 : 4);
        si = int'($signed(cfg_inner_step_i)) * scale;
        so = int'($signed(cfg_outer_step_i)) * scale;
        a  = cfg_base_i;
        for (int p = 0; p < passes; p++) begin
            for (int o = 0; o < n_out; o++) begin
                for (int i = 0; i < n_in; i++) begin
                    exp_t e;
                    e.a   = a;
                    e.irq = (i == n_in - 1) && ((o == n_out - 1) || cfg_row_irq_i);
                    q.push_back(e);
                    if (i < n_in - 1)      a = a + 32'(si);
                    else if (o < n_out - 1) a = a + 32'(so);
                    else                    a = cfg_base_i;
                end
            end
        end
    endtask

    task automatic drive_adv(input int n, input bit gappy);
        for (int k = 0; k < n; k++) begin
            advance_i = 1'b1;
            cyc();
            advance_i = 1'b0;
            if (gappy) begin
                cyc();
            end
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 32'h0, 32'h1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        repeat (3) cyc();
        // R1: reset state
        chk(busy_o === 1'b0, "R1", "busy after reset", {31'd0, busy_o}, 32'h0);
        chk(done_o === 1'b0, "R1", "done after reset", {31'd0, done_o}, 32'h0);
        chk(irq_o === 1'b0, "R1", "irq after reset", {31'd0, irq_o}, 32'h0);
        chk(addr_o === 32'h0, "R1", "addr after reset", addr_o, 32'h0);
        rst_n = 1'b1;
        cyc();
        mon_on = 1'b1;

        // Test A: 2D stop, outer step below inner step (de-interleave) - R2 R3 R4 R5
        cfg_start(32'h100, 16'd4, 16'd3, 16'd3, -16'sd8, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(busy_o === 1'b1, "R2", "busy after start", {31'd0, busy_o}, 32'h1);
        chk(addr_o === 32'h100, "R2", "base after start", addr_o, 32'h100);
        chk(done_o === 1'b0, "R2", "done after start", {31'd0, done_o}, 32'h0);
        push_expected(1);
        drive_adv(12, 1'b0);
        cyc();
        chk(q.size() == 0, "R5", "elements left", 32'(q.size()), 32'h0);
        chk(done_o === 1'b1, "R5", "done at end", {31'd0, done_o}, 32'h1);
        chk(busy_o === 1'b0, "R5", "busy at end", {31'd0, busy_o}, 32'h0);
        drive_adv(3, 1'b0);
        chk(addr_o === last_addr, "R5", "addr ignores advance when idle", addr_o, last_addr);
        chk(done_o === 1'b1, "R5", "done holds", {31'd0, done_o}, 32'h1);
        chk(last_addr === 32'h10B, "R4", "final de-interleaved addr", last_addr, 32'h10B);

        // Test B: circular, row irq, element size code 3, gappy advance - R6 R7 R12
        cfg_start(32'h2000, 16'd3, 16'd1, 16'd2, 16'd5, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0);
        push_expected(3);
        drive_adv(2, 1'b0);
        cyc(); cyc(); cyc();
        chk(addr_o === 32'h2008, "R12", "addr holds without advance", addr_o, 32'h2008);
        drive_adv(16, 1'b1);
        cyc();
        chk(q.size() == 0, "R6", "elements left", 32'(q.size()), 32'h0);
        chk(busy_o === 1'b1, "R6", "busy after passes", {31'd0, busy_o}, 32'h1);
        chk(addr_o === 32'h2000, "R6", "reloaded base", addr_o, 32'h2000);
        chk(done_o === 1'b0, "R6", "no done in circular", {31'd0, done_o}, 32'h0);

        // Test C: 1D with outer fields ignored, negative step, wrap - R9 R10
        cfg_start(32'h8, 16'd5, -16'sd2, 16'd7, 16'd100, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        push_expected(1);
        drive_adv(5, 1'b0);
        cyc();
        chk(done_o === 1'b1, "R9", "1D done after inner count", {31'd0, done_o}, 32'h1);
        chk(last_addr === 32'hFFFFFFF8, "R10", "wrapped addr", last_addr, 32'hFFFFFFF8);

        // Test D: restart while busy, start with advance in same cycle - R11
        cfg_start(32'h400, 16'd4, 16'd1, 16'd1, 16'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
        push_expected(1);
        drive_adv(2, 1'b0);
        q.delete();
        cfg_start(32'h900, 16'd2, 16'd2, 16'd2, 16'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        chk(addr_o === 32'h900, "R11", "restart base", addr_o, 32'h900);
        chk(busy_o === 1'b1, "R11", "busy after restart", {31'd0, busy_o}, 32'h1);
        push_expected(1);
        drive_adv(4, 1'b0);
        cyc();
        chk(q.size() == 0, "R11", "restart stream consumed", 32'(q.size()), 32'h0);
        chk(done_o === 1'b1, "R11", "restart stream done", {31'd0, done_o}, 32'h1);

        // Test E: count 0 means 65536 - R8
        cfg_start(32'h0, 16'd0, 16'd1, 16'd0, 16'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        push_expected(1);
        drive_adv(65535, 1'b0);
        chk(busy_o === 1'b1, "R8", "busy before element 65536", {31'd0, busy_o}, 32'h1);
        drive_adv(1, 1'b0);
        cyc();
        chk(done_o === 1'b1, "R8", "done after 65536", {31'd0, done_o}, 32'h1);
        chk(last_addr === 32'h0000FFFF, "R8", "last addr", last_addr, 32'h0000FFFF);

        cyc();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule